// File: doc/BRIEF.md
# Receiver Sleep Gate for a Byte-Level Serial Bus Decoder

This block keeps the receiver sleep state of a byte-level bus decoder and decides, event by event, whether a received byte and its status and error strobes reach the host side. Software can put the receiver to sleep but cannot wake it. Only a bus symbol wakes the receiver: an end-of-frame or a break. A transmit timeout forces the receiver back to sleep. So does any period in which the peripheral is disabled or not enabled.

While asleep, the block's filtering depends on whether the node is driving the bus itself. When the node is idle, every receive-side strobe is dropped. When the node is transmitting, the byte load, the data-ready strobe, the overrun strobe and the end-of-data strobe are dropped. The CRC, framing and bit-level error strobes still pass, so the node can detect faults in its own transmission. Gating uses the sleep value held before the clock edge. A byte that completes on the same cycle as a waking symbol is therefore still filtered.

Top module: `rx_sleep_gate`

## Requirements
- R1: While `rst_n` is low, `sleep_o` reads 1 after the next rising clock edge.
- R2: A `tx_timeout_i` pulse makes `sleep_o` read 1 after that edge. This holds even when `eof_sym_i` or `brk_sym_i` is high in the same cycle.
- R3: While `enable_i` is low or `disable_i` is high, `sleep_o` stays 1, and wake symbols have no effect.
- R4: With the block enabled, not disabled and no timeout, an `eof_sym_i` pulse makes `sleep_o` read 0 after that edge.
- R5: Under the same conditions as R4, a `brk_sym_i` pulse makes `sleep_o` read 0 after that edge.
- R6: A write with `sw_sleep_wr_i`=1 and `sw_sleep_wdata_i`=1 sets `sleep_o` after that edge, and it wins over a wake symbol in the same cycle. A write with data 0 leaves `sleep_o` unchanged.
- R7: While `sleep_o` is 0, each gated output equals its raw input in the same cycle. Both `rxbuf_load_o` and `data_ready_o` follow `ev_data_ready_i`.
- R8: While `sleep_o` is 1 and `transmitting_i` is 0, all seven gated outputs are 0.
- R9: While `sleep_o` is 1 and `transmitting_i` is 1, `rxbuf_load_o`, `data_ready_o`, `overrun_o` and `end_data_o` are 0. `crc_err_o`, `bad_frame_o` and `bad_bit_o` equal their raw inputs.
- R10: Gating uses the sleep value held before the edge. An event that arrives in the same cycle as a wake symbol is suppressed. The same event one cycle later passes.
- R11: With no set, clear or reset condition present, `sleep_o` keeps its value from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| eof_sym_i | input | 1 | End-of-frame symbol strobe |
| brk_sym_i | input | 1 | Break symbol strobe |
| tx_timeout_i | input | 1 | Transmit timeout strobe |
| enable_i | input | 1 | Peripheral enable level |
| disable_i | input | 1 | Peripheral disable level |
| transmitting_i | input | 1 | Node is driving the bus |
| sw_sleep_wr_i | input | 1 | Software write strobe for the sleep bit |
| sw_sleep_wdata_i | input | 1 | Software write value for the sleep bit |
| ev_data_ready_i | input | 1 | Raw byte-received strobe |
| ev_overrun_i | input | 1 | Raw overrun strobe |
| ev_crc_err_i | input | 1 | Raw CRC error strobe |
| ev_bad_frame_i | input | 1 | Raw invalid-frame strobe |
| ev_bad_bit_i | input | 1 | Raw invalid-bit strobe |
| ev_end_data_i | input | 1 | Raw end-of-data strobe |
| sleep_o | output | 1 | Current sleep state |
| rxbuf_load_o | output | 1 | Write strobe into the receive data register |
| data_ready_o | output | 1 | Gated data-ready strobe |
| overrun_o | output | 1 | Gated overrun strobe |
| crc_err_o | output | 1 | Gated CRC error strobe |
| bad_frame_o | output | 1 | Gated invalid-frame strobe |
| bad_bit_o | output | 1 | Gated invalid-bit strobe |
| end_data_o | output | 1 | Gated end-of-data strobe |

## Verification
The sleep state is a single register that drives `sleep_o` directly. A wrong update shows on that port one edge after the cycle that caused it, including a wrong choice of winner when a set and a clear arrive together. A wrong gating policy stays hidden until the affected raw strobe pulses. It then shows combinationally in the same cycle, so the bench drives each strobe in both sleep sub-modes and also while awake. The same-cycle case of a wake symbol and a byte event shows whether gating reads the old state or the new one.

// File: rtl/rsg_pkg.sv
// Shared definitions for the receiver sleep gate.
// Assumes a fixed set of seven gated outputs; the index order below is
// the order of the gated vector used between the top and the gate array.
package rsg_pkg;

    localparam int NUM_GATED = 7;

    localparam int G_LOAD    = 0;
    localparam int G_READY   = 1;
    localparam int G_OVERRUN = 2;
    localparam int G_CRC     = 3;
    localparam int G_FRAME   = 4;
    localparam int G_BIT     = 5;
    localparam int G_EOD     = 6;

    // Bit set = output suppressed while asleep in that sub-mode.
    localparam logic [NUM_GATED-1:0] SUPP_WHEN_IDLE = 7'b111_1111;
    localparam logic [NUM_GATED-1:0] SUPP_WHEN_TX   = 7'b100_0111;

    // Decoded requests acting on the sleep register.
    typedef struct packed {
        logic force_set;   // timeout, not enabled, or disabled
        logic sw_set;      // software writes a one
        logic sym_clr;     // end-of-frame or break seen
    } sleep_req_t;

endpackage

// File: rtl/rsg_sleep_ctrl.sv
// Sleep state register.
// Priority, highest first: reset, forced set, software set, symbol clear,
// hold. Assumes all strobes are synchronous and one cycle wide.
module rsg_sleep_ctrl
    import rsg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic eof_sym_i,
    input  logic brk_sym_i,
    input  logic tx_timeout_i,
    input  logic enable_i,
    input  logic disable_i,
    input  logic sw_sleep_wr_i,
    input  logic sw_sleep_wdata_i,
    output logic sleep_q_o
);

    sleep_req_t req;
    logic       sleep_d;
    logic       sleep_q;

    // Decode raw controls into set and clear requests.
    always_comb begin
        req.force_set = tx_timeout_i | ~enable_i | disable_i;
        req.sw_set    = sw_sleep_wr_i & sw_sleep_wdata_i;
        req.sym_clr   = eof_sym_i | brk_sym_i;
    end

    // Resolve requests by priority; set conditions dominate clear.
    always_comb begin
        if (req.force_set || req.sw_set) begin
            sleep_d = 1'b1;
        end else if (req.sym_clr) begin
            sleep_d = 1'b0;
        end else begin
            sleep_d = sleep_q;
        end
    end

    // Sleep register with synchronous active-low reset to one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sleep_q <= 1'b1;
        end else begin
            sleep_q <= sleep_d;
        end
    end

    assign sleep_q_o = sleep_q;

endmodule

// File: rtl/rsg_gate_cell.sv
// One gated event path. The parameters choose whether the event is
// dropped while asleep with the node idle and/or transmitting.
// Assumes sleep_i is the registered state, so the output is pure logic.
module rsg_gate_cell #(
    parameter bit SUPP_IDLE = 1'b1,
    parameter bit SUPP_TX   = 1'b1
) (
    input  logic raw_i,
    input  logic sleep_i,
    input  logic tx_i,
    output logic gated_o
);

    generate
        if (SUPP_IDLE && SUPP_TX) begin : g_always
            // Dropped in both sleep sub-modes.
            always_comb gated_o = raw_i & ~sleep_i;
        end else if (SUPP_IDLE) begin : g_idle_only
            // Dropped only when asleep and not transmitting.
            always_comb gated_o = raw_i & ~(sleep_i & ~tx_i);
        end else if (SUPP_TX) begin : g_tx_only
            // Dropped only when asleep and transmitting.
            always_comb gated_o = raw_i & ~(sleep_i & tx_i);
        end else begin : g_never
            // Never dropped; sleep has no bearing on this path.
            always_comb gated_o = raw_i | (sleep_i & tx_i & 1'b0);
        end
    endgenerate

endmodule

// File: rtl/rsg_event_gate.sv
// Array of gate cells, one per gated output, each with its own policy
// taken from the two suppression masks.
module rsg_event_gate #(
    parameter int                   N         = rsg_pkg::NUM_GATED,
    parameter logic [N-1:0]         MASK_IDLE = rsg_pkg::SUPP_WHEN_IDLE,
    parameter logic [N-1:0]         MASK_TX   = rsg_pkg::SUPP_WHEN_TX
) (
    input  logic [N-1:0] raw_i,
    input  logic         sleep_i,
    input  logic         tx_i,
    output logic [N-1:0] gated_o
);

    generate
        for (genvar i = 0; i < N; i++) begin : g_cell
            rsg_gate_cell #(
                .SUPP_IDLE (MASK_IDLE[i]),
                .SUPP_TX   (MASK_TX[i])
            ) u_cell (
                .raw_i   (raw_i[i]),
                .sleep_i (sleep_i),
                .tx_i    (tx_i),
                .gated_o (gated_o[i])
            );
        end
    endgenerate

endmodule

// File: rtl/rx_sleep_gate.sv
// Top of the receiver sleep gate: holds the sleep state and filters the
// per-byte receive strobes. Assumes single-cycle strobes and synchronous
// inputs; gated outputs are combinational from the raw events.
module rx_sleep_gate
    import rsg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic eof_sym_i,
    input  logic brk_sym_i,
    input  logic tx_timeout_i,
    input  logic enable_i,
    input  logic disable_i,
    input  logic transmitting_i,
    input  logic sw_sleep_wr_i,
    input  logic sw_sleep_wdata_i,
    input  logic ev_data_ready_i,
    input  logic ev_overrun_i,
    input  logic ev_crc_err_i,
    input  logic ev_bad_frame_i,
    input  logic ev_bad_bit_i,
    input  logic ev_end_data_i,
    output logic sleep_o,
    output logic rxbuf_load_o,
    output logic data_ready_o,
    output logic overrun_o,
    output logic crc_err_o,
    output logic bad_frame_o,
    output logic bad_bit_o,
    output logic end_data_o
);

    logic                 sleep_q;
    logic [NUM_GATED-1:0] raw_vec;
    logic [NUM_GATED-1:0] gated_vec;

    rsg_sleep_ctrl u_ctrl (
        .clk              (clk),
        .rst_n            (rst_n),
        .eof_sym_i        (eof_sym_i),
        .brk_sym_i        (brk_sym_i),
        .tx_timeout_i     (tx_timeout_i),
        .enable_i         (enable_i),
        .disable_i        (disable_i),
        .sw_sleep_wr_i    (sw_sleep_wr_i),
        .sw_sleep_wdata_i (sw_sleep_wdata_i),
        .sleep_q_o        (sleep_q)
    );

    // Map raw events into the gate vector; load and ready share a source.
    always_comb begin
        raw_vec            = '0;
        raw_vec[G_LOAD]    = ev_data_ready_i;
        raw_vec[G_READY]   = ev_data_ready_i;
        raw_vec[G_OVERRUN] = ev_overrun_i;
        raw_vec[G_CRC]     = ev_crc_err_i;
        raw_vec[G_FRAME]   = ev_bad_frame_i;
        raw_vec[G_BIT]     = ev_bad_bit_i;
        raw_vec[G_EOD]     = ev_end_data_i;
    end

    rsg_event_gate #(
        .N         (NUM_GATED),
        .MASK_IDLE (SUPP_WHEN_IDLE),
        .MASK_TX   (SUPP_WHEN_TX)
    ) u_gate (
        .raw_i   (raw_vec),
        .sleep_i (sleep_q),
        .tx_i    (transmitting_i),
        .gated_o (gated_vec)
    );

    // Drive the ports from the gate vector.
    always_comb begin
        sleep_o      = sleep_q;
        rxbuf_load_o = gated_vec[G_LOAD];
        data_ready_o = gated_vec[G_READY];
        overrun_o    = gated_vec[G_OVERRUN];
        crc_err_o    = gated_vec[G_CRC];
        bad_frame_o  = gated_vec[G_FRAME];
        bad_bit_o    = gated_vec[G_BIT];
        end_data_o   = gated_vec[G_EOD];
    end

endmodule

// File: rtl/rx_sleep_gate_chk.sv
// Port-level checker for rx_sleep_gate, attached with bind below.
module rx_sleep_gate_chk (
    input logic clk,
    input logic rst_n,
    input logic eof_sym_i,
    input logic brk_sym_i,
    input logic tx_timeout_i,
    input logic enable_i,
    input logic disable_i,
    input logic transmitting_i,
    input logic sw_sleep_wr_i,
    input logic sw_sleep_wdata_i,
    input logic ev_data_ready_i,
    input logic ev_overrun_i,
    input logic ev_crc_err_i,
    input logic ev_bad_frame_i,
    input logic ev_bad_bit_i,
    input logic ev_end_data_i,
    input logic sleep_o,
    input logic rxbuf_load_o,
    input logic data_ready_o,
    input logic overrun_o,
    input logic crc_err_o,
    input logic bad_frame_o,
    input logic bad_bit_o,
    input logic end_data_o
);

    logic quiet_ctrl;
    assign quiet_ctrl = enable_i && !disable_i && !tx_timeout_i;

    a_r1_reset_sleeps: assert property (@(posedge clk)
        !rst_n |=> sleep_o);

    a_r2_timeout_sets: assert property (@(posedge clk) disable iff (!rst_n)
        tx_timeout_i |=> sleep_o);

    a_r3_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable_i || disable_i) |=> sleep_o);

    a_r4_r5_symbol_wakes: assert property (@(posedge clk) disable iff (!rst_n)
        ((eof_sym_i || brk_sym_i) && quiet_ctrl
         && !(sw_sleep_wr_i && sw_sleep_wdata_i)) |=> !sleep_o);

    a_r6_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_sleep_wr_i && sw_sleep_wdata_i) |=> sleep_o);

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_ctrl && !eof_sym_i && !brk_sym_i
         && !(sw_sleep_wr_i && sw_sleep_wdata_i)) |=> $stable(sleep_o));

    a_r7_awake_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_o |-> (rxbuf_load_o == ev_data_ready_i
                      && data_ready_o == ev_data_ready_i
                      && overrun_o == ev_overrun_i
                      && crc_err_o == ev_crc_err_i
                      && bad_frame_o == ev_bad_frame_i
                      && bad_bit_o == ev_bad_bit_i
                      && end_data_o == ev_end_data_i));

    a_r8_idle_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_o && !transmitting_i) |->
            $countones({rxbuf_load_o, data_ready_o, overrun_o, crc_err_o,
                        bad_frame_o, bad_bit_o, end_data_o}) == 0);

    a_r9_tx_sleep_errors: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_o && transmitting_i) |->
            (!rxbuf_load_o && !data_ready_o && !overrun_o && !end_data_o
             && crc_err_o == ev_crc_err_i && bad_frame_o == ev_bad_frame_i
             && bad_bit_o == ev_bad_bit_i));

endmodule

bind rx_sleep_gate rx_sleep_gate_chk u_chk (.*);

// File: tb/tb_rx_sleep_gate.sv
module tb_rx_sleep_gate;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic eof_sym_i = 0, brk_sym_i = 0, tx_timeout_i = 0;
    logic enable_i = 1, disable_i = 0, transmitting_i = 0;
    logic sw_sleep_wr_i = 0, sw_sleep_wdata_i = 0;
    logic [5:0] raw = '0;   // {eod, bit, frame, crc, ovr, ready}
    logic sleep_o, rxbuf_load_o, data_ready_o, overrun_o;
    logic crc_err_o, bad_frame_o, bad_bit_o, end_data_o;
    logic [6:0] outs;       // {eod, bit, frame, crc, ovr, ready, load}

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rx_sleep_gate dut (
        .clk(clk), .rst_n(rst_n),
        .eof_sym_i(eof_sym_i), .brk_sym_i(brk_sym_i), .tx_timeout_i(tx_timeout_i),
        .enable_i(enable_i), .disable_i(disable_i), .transmitting_i(transmitting_i),
        .sw_sleep_wr_i(sw_sleep_wr_i), .sw_sleep_wdata_i(sw_sleep_wdata_i),
        .ev_data_ready_i(raw[0]), .ev_overrun_i(raw[1]), .ev_crc_err_i(raw[2]),
        .ev_bad_frame_i(raw[3]), .ev_bad_bit_i(raw[4]), .ev_end_data_i(raw[5]),
        .sleep_o(sleep_o), .rxbuf_load_o(rxbuf_load_o), .data_ready_o(data_ready_o),
        .overrun_o(overrun_o), .crc_err_o(crc_err_o), .bad_frame_o(bad_frame_o),
        .bad_bit_o(bad_bit_o), .end_data_o(end_data_o)
    );

    assign outs = {end_data_o, bad_bit_o, bad_frame_o, crc_err_o,
                   overrun_o, data_ready_o, rxbuf_load_o};

    // Expected gated vector from the requirements.
    function automatic logic [6:0] expect_outs(logic [5:0] r, logic slp, logic tx);
        logic [6:0] full;
        full = {r, r[0]};
        if (!slp) return full;                       // R7
        if (!tx) return 7'b0;                        // R8
        return full & 7'b011_1000;                   // R9: crc, frame, bit pass
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Advance one edge and settle past it.
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic go_sleep();
        sw_sleep_wr_i = 1; sw_sleep_wdata_i = 1; step();
        sw_sleep_wr_i = 0; sw_sleep_wdata_i = 0;
    endtask

    task automatic go_awake();
        eof_sym_i = 1; step(); eof_sym_i = 0;
    endtask

    task automatic t_reset();
        step(); step();
        chk("R1 sleep in reset", sleep_o, 1);
        rst_n = 1; step();
        chk("R1 sleep after reset", sleep_o, 1);
    endtask

    task automatic t_eof_clear();
        go_awake();
        chk("R4 eof wakes", sleep_o, 0);
    endtask

    task automatic t_awake_pass();
        logic [5:0] pats [4] = '{6'b000001, 6'b101010, 6'b010101, 6'b111111};
        foreach (pats[i]) begin
            raw = pats[i]; #1;
            chk("R7 awake pass", outs, expect_outs(pats[i], 0, 0));
            transmitting_i = 1; #1;
            chk("R7 awake pass tx", outs, expect_outs(pats[i], 0, 1));
            transmitting_i = 0;
        end
        raw = 0;
    endtask

    task automatic t_sw_write();
        sw_sleep_wr_i = 1; sw_sleep_wdata_i = 0; step(); sw_sleep_wr_i = 0;
        chk("R6 write zero awake", sleep_o, 0);
        go_sleep();
        chk("R6 write one sets", sleep_o, 1);
        sw_sleep_wr_i = 1; sw_sleep_wdata_i = 0; step(); sw_sleep_wr_i = 0;
        chk("R6 write zero asleep", sleep_o, 1);
    endtask

    task automatic t_break_clear();
        brk_sym_i = 1; step(); brk_sym_i = 0;
        chk("R5 break wakes", sleep_o, 0);
    endtask

    task automatic t_sleep_idle();
        go_sleep();
        transmitting_i = 0;
        raw = 6'b111111; #1;
        chk("R8 idle sleep all", outs, 0);
        raw = 6'b100000; #1;
        chk("R8 idle sleep eod", outs, 0);
        raw = 0;
    endtask

    task automatic t_sleep_tx();
        transmitting_i = 1;
        raw = 6'b111111; #1;
        chk("R9 tx sleep all", outs, expect_outs(6'b111111, 1, 1));
        raw = 6'b100011; #1;
        chk("R9 tx sleep rx side", outs, 0);
        raw = 6'b011100; #1;
        chk("R9 tx sleep errors", outs, 7'b0111000);
        raw = 0; transmitting_i = 0;
    endtask

    task automatic t_coincident();
        eof_sym_i = 1; raw = 6'b000001; #1;
        chk("R10 same-cycle load", rxbuf_load_o, 0);
        chk("R10 same-cycle ready", data_ready_o, 0);
        step(); eof_sym_i = 0; #1;
        chk("R10 next-cycle ready", data_ready_o, 1);
        chk("R10 next-cycle load", rxbuf_load_o, 1);
        raw = 0;
    endtask

    task automatic t_hold();
        repeat (5) step();
        chk("R11 hold awake", sleep_o, 0);
    endtask

    task automatic t_timeout();
        tx_timeout_i = 1; eof_sym_i = 1; step();
        tx_timeout_i = 0; eof_sym_i = 0;
        chk("R2 timeout beats eof", sleep_o, 1);
        go_awake();
        tx_timeout_i = 1; step(); tx_timeout_i = 0;
        chk("R2 timeout sets", sleep_o, 1);
    endtask

    task automatic t_off();
        disable_i = 1; eof_sym_i = 1; step();
        brk_sym_i = 1; eof_sym_i = 0; step();
        chk("R3 disabled ignores symbols", sleep_o, 1);
        disable_i = 0; brk_sym_i = 0;
        go_awake();
        enable_i = 0; step();
        chk("R3 not enabled forces sleep", sleep_o, 1);
        eof_sym_i = 1; step(); eof_sym_i = 0;
        chk("R3 not enabled ignores eof", sleep_o, 1);
        enable_i = 1; go_awake();
        chk("R4 eof after enable", sleep_o, 0);
    endtask

    task automatic t_sw_vs_sym();
        sw_sleep_wr_i = 1; sw_sleep_wdata_i = 1; eof_sym_i = 1; step();
        sw_sleep_wr_i = 0; sw_sleep_wdata_i = 0; eof_sym_i = 0;
        chk("R6 sw set beats eof", sleep_o, 1);
        repeat (3) step();
        chk("R11 hold asleep", sleep_o, 1);
    endtask

    initial begin
        t_reset();
        t_eof_clear();
        t_awake_pass();
        t_sw_write();
        t_break_clear();
        t_sleep_idle();
        t_sleep_tx();
        t_coincident();
        t_hold();
        t_timeout();
        t_off();
        t_sw_vs_sym();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule